// File: doc/BRIEF.md
# Half-Step Frame Clock Divider

This block runs on the codec clock, which is fixed at 256 times the reference sample rate. It derives two independent frame clocks from it, one for the playback converter path and one for the record converter path. Each path divides the reference rate by its own N, which is set in half steps from 1 to 6. A per-path double-rate switch overrides the divisor to 0.5.

The frame period of a path is 256×N codec cycles, so it is always a whole multiple of 128 cycles. Each path produces a frame clock with 50% duty and a one-cycle strobe on the cycle where that clock rises. The playback frame clock drives the word clock pin. The record frame clock can be routed onto a general-purpose output.

Settings may change at any time. A path loads new settings only when it starts a new frame.

Top module: `frame_clk_div`

## Requirements
- R1: In the first codec cycle after reset is released, each path's strobe is high and its frame clock is high. That cycle is the start of frame 0.
- R2: For a divisor code k in 0..10 with double-rate off, the frame period is 128×(k+2) codec cycles, which gives N = 1 + 0.5×k.
- R3: Divisor codes 11 to 15 act as code 10, which gives a period of 1536 cycles (N = 6).
- R4: When a path's double-rate input is 1, that path's period is 128 cycles whatever its code.
- R5: The frame clock is high for the first half of each period and low for the second half. The strobe is high for one cycle only, at the start of each period, which is the cycle where the frame clock rises.
- R6: A change of code or double-rate input takes effect only at the next frame start of that path. The frame already running keeps its length.
- R7: `word_clk` and `play_strobe` carry the playback path's frame clock and strobe.
- R8: When `rec_route` is 1, `gp_out` follows the record frame clock. When `rec_route` is 0, `gp_out` is 0.
- R9: The two paths run independently. When both paths have the same effective divisor, their strobes coincide on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec clock, 256× the reference sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_code | input | 4 | Playback divisor code k (N = 1 + 0.5k) |
| play_double | input | 1 | Playback double-rate override (N = 0.5) |
| rec_code | input | 4 | Record divisor code k |
| rec_double | input | 1 | Record double-rate override |
| rec_route | input | 1 | Routes the record frame clock onto gp_out |
| word_clk | output | 1 | Playback frame clock |
| play_strobe | output | 1 | Playback frame-start strobe |
| rec_fclk | output | 1 | Record frame clock |
| rec_strobe | output | 1 | Record frame-start strobe |
| gp_out | output | 1 | General-purpose output carrying the routed record clock |

## Verification
The assertions check on every cycle that each strobe coincides with a rising frame clock. They check that the gap between strobes is a multiple of 128 cycles within the legal range, that the high time of each frame is exactly half its length, and that the general-purpose output follows the routing input. Only the bench's scenarios can show that a given code or double-rate setting produces its exact period, including the clamping of the high codes. The same holds for the deferral of a mid-frame change until the next frame start, and for the phase alignment of two paths set to equal divisors.

// File: rtl/frame_clk_div.sv
module frame_clk_div #(
  parameter int CODE_W    = 4,
  parameter int MAX_CODE  = 10,
  parameter int HALF_UNIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] play_code,
  input  logic              play_double,
  input  logic [CODE_W-1:0] rec_code,
  input  logic              rec_double,
  input  logic              rec_route,
  output logic              word_clk,
  output logic              play_strobe,
  output logic              rec_fclk,
  output logic              rec_strobe,
  output logic              gp_out
);
  localparam int MAX_UNITS = MAX_CODE + 2;
  localparam int UW        = $clog2(MAX_UNITS + 1);
  localparam int CNT_W     = $clog2(HALF_UNIT * MAX_UNITS);

  logic [1:0] fclk_v, stb_v;

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [CODE_W-1:0] code_raw, code_c;
    logic              dbl;
    logic [UW-1:0]     units_in, units_q, units_act;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    period, half;

    assign code_raw  = (g == 0) ? play_code : rec_code;
    assign dbl       = (g == 0) ? play_double : rec_double;
    assign code_c    = (code_raw > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_raw;
    assign units_in  = dbl ? UW'(1) : UW'(code_c) + UW'(2);
    assign units_act = (cnt == '0) ? units_in : units_q;
    assign period    = (CNT_W+1)'(units_act) * (CNT_W+1)'(HALF_UNIT);
    assign half      = period >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        units_q <= UW'(2);
      end else begin
        units_q <= units_act;
        if ({1'b0, cnt} == period - 1'b1) cnt <= '0;
        else                              cnt <= cnt + 1'b1;
      end
    end

    assign fclk_v[g] = ({1'b0, cnt} < half);
    assign stb_v[g]  = (cnt == '0);
  end

  assign word_clk    = fclk_v[0];
  assign play_strobe = stb_v[0];
  assign rec_fclk    = fclk_v[1];
  assign rec_strobe  = stb_v[1];
  assign gp_out      = rec_route & fclk_v[1];
endmodule

// File: rtl/frame_clk_div_chk.sv
module frame_clk_div_chk #(
  parameter int HALF_UNIT = 128,
  parameter int MAX_UNITS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic word_clk,
  input logic play_strobe,
  input logic rec_fclk,
  input logic rec_strobe,
  input logic rec_route,
  input logic gp_out
);
  localparam int GW = $clog2(HALF_UNIT * MAX_UNITS) + 2;
  logic [1:0] fc, st;
  assign fc = {rec_fclk, word_clk};
  assign st = {rec_strobe, play_strobe};

  for (genvar g = 0; g < 2; g++) begin : g_mon
    logic [GW-1:0] gap, hi;
    logic          seen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap <= '0; hi <= '0; seen <= 1'b0;
      end else if (st[g]) begin
        gap <= GW'(1); hi <= GW'(1); seen <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
        hi  <= hi + GW'(fc[g]);
      end
    end

    p_frame_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] && seen) |-> ((gap % GW'(HALF_UNIT)) == '0 && gap >= GW'(HALF_UNIT)
                           && gap <= GW'(HALF_UNIT * MAX_UNITS)));
    p_duty_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] && seen) |-> (hi == (gap >> 1)));
    p_rise_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fc[g]) |-> st[g]);
    p_strobe_when_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] |-> fc[g]);
  end

  p_gp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_route |-> (gp_out == rec_fclk));
  p_gp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_route |-> !gp_out);
endmodule

bind frame_clk_div frame_clk_div_chk #(.HALF_UNIT(HALF_UNIT), .MAX_UNITS(MAX_CODE + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .play_strobe(play_strobe),
  .rec_fclk(rec_fclk), .rec_strobe(rec_strobe), .rec_route(rec_route), .gp_out(gp_out)
);

// File: tb/sim_frame_clk_div.sv
`timescale 1ns/1ps
module sim_frame_clk_div;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] play_code = '0, rec_code = '0;
  logic play_double = 1'b0, rec_double = 1'b0, rec_route = 1'b0;
  logic word_clk, play_strobe, rec_fclk, rec_strobe, gp_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  frame_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .play_code(play_code), .play_double(play_double),
    .rec_code(rec_code), .rec_double(rec_double), .rec_route(rec_route),
    .word_clk(word_clk), .play_strobe(play_strobe), .rec_fclk(rec_fclk),
    .rec_strobe(rec_strobe), .gp_out(gp_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input logic [3:0] k, input logic dbl);
    if (dbl) return 128;
    return 128 * (((k > 10) ? 10 : int'(k)) + 2);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run_cfg(input logic [3:0] pc, input logic pd, input logic [3:0] rc,
                         input logic rd, input logic route);
    int pp, pr, tmax;
    int ns_p = 0, ns_r = 0, t1p = -1, t2p = -1, t1r = -1, t2r = -1;
    int hip = 0, hir = 0, bad_rise = 0, bad_gp = 0, bad_align = 0;
    logic prev_p = 1'b1, prev_r = 1'b1;
    play_code = pc; play_double = pd; rec_code = rc; rec_double = rd; rec_route = route;
    pp = exp_period(pc, pd);
    pr = exp_period(rc, rd);
    tmax = ((pp > pr) ? pp : pr) + 2;
    do_reset();
    for (int t = 0; t <= tmax; t++) begin
      if (t > 0) begin @(negedge clk); #1; end
      if (play_strobe) begin ns_p++; if (ns_p == 1) t1p = t; if (ns_p == 2) t2p = t; end
      if (rec_strobe)  begin ns_r++; if (ns_r == 1) t1r = t; if (ns_r == 2) t2r = t; end
      if (ns_p == 1 && word_clk) hip++;
      if (ns_r == 1 && rec_fclk) hir++;
      if (t > 0 && ((word_clk && !prev_p) != play_strobe)) bad_rise++;
      if (t > 0 && ((rec_fclk && !prev_r) != rec_strobe)) bad_rise++;
      if (gp_out != (route & rec_fclk)) bad_gp++;
      if (pp == pr && play_strobe != rec_strobe) bad_align++;
      prev_p = word_clk; prev_r = rec_fclk;
    end
    chk("R1 play first strobe", t1p, 0);
    chk("R1 rec first strobe", t1r, 0);
    chk(pd ? "R4 play period" : (pc > 10 ? "R3 play period" : "R2 play period"), t2p - t1p, pp);
    chk(rd ? "R4 rec period" : (rc > 10 ? "R3 rec period" : "R2 rec period"), t2r - t1r, pr);
    chk("R5 play high time", hip, pp / 2);
    chk("R5 rec high time", hir, pr / 2);
    chk("R5 strobe at rise", bad_rise, 0);
    chk("R8 gp routing", bad_gp, 0);
    if (pp == pr) chk("R9 strobes aligned", bad_align, 0);
  endtask

  task automatic run_change();
    int sp[3], sr[3];
    int np = 0, nr = 0, wc_mis = 0;
    play_code = 4'd0; play_double = 1'b0; rec_code = 4'd0; rec_double = 1'b0; rec_route = 1'b1;
    do_reset();
    for (int t = 0; t <= 800; t++) begin
      if (t > 0) begin @(negedge clk); #1; end
      if (t == 10) begin play_code = 4'd2; rec_double = 1'b1; end
      if (play_strobe && np < 3) begin sp[np] = t; np++; end
      if (rec_strobe && nr < 3) begin sr[nr] = t; nr++; end
      if (t >= 10 && t < 256 && !play_strobe && t == 128) wc_mis += word_clk ? 1 : 0;
    end
    chk("R6 play frame kept", sp[1], 256);
    chk("R6 play new period", sp[2], 768);
    chk("R6 rec frame kept", sr[1], 256);
    chk("R6 rec new period", sr[2], 384);
    chk("R6 old duty kept", wc_mis, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    chk("R7 word clock during reset", int'(word_clk), 1);
    for (int k = 0; k < 16; k++)
      run_cfg(4'(k), 1'b0, 4'(15 - k), 1'b0, k[0]);
    run_cfg(4'd3, 1'b1, 4'd3, 1'b0, 1'b1);
    run_cfg(4'd0, 1'b0, 4'd7, 1'b1, 1'b0);
    run_cfg(4'd12, 1'b1, 4'd12, 1'b1, 1'b1);
    run_cfg(4'd4, 1'b0, 4'd4, 1'b0, 1'b1);
    run_cfg(4'd15, 1'b0, 4'd11, 1'b0, 1'b0);
    run_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule